// File: doc/BRIEF.md
# Peripheral Register Write-Protection Wrapper

This block sits between a simple single-cycle peripheral bus and a small bank of 32-bit module registers. It guards the registers against stray writes. Each register byte has a soft lock bit. A bus write to a locked byte leaves that byte unchanged and returns an error. Writes to the unlocked bytes of the same word still go through. The bank is reachable through two address windows. The alias window writes the register exactly like the plain window, and it also locks every byte it writes. Software can therefore lock a value and write it in one access.

Lock bits can also be changed directly in a lock window. Each lock byte carries a nibble of per-bit write enables above a nibble of lock values, so single bits can be set or cleared without a read-modify-write. A configuration word holds two bits. The first is a sticky hard lock that freezes every lock bit until reset. The second is a user-access enable: while it is 0, accesses marked as user mode are refused. A parameter mask marks which bytes of each register can be locked at all. The lock bits of the other bytes always read 0.

Every request receives exactly one response, one clock later. The response carries the read data and an error flag. Writes return zero data.

Top module: `reg_prot_wrap`

## Requirements
- R1: A plain-window write (offset 4*i) updates only the bytes of register i whose strobe bus_be[b] is 1 and whose lock bit is 0. A read of offset 4*i and a read of offset 0x2000+4*i both return the register value with no error. bus_addr[1:0] is ignored.
- R2: A write to the alias window (offset 0x2000+4*i) updates register i exactly as a plain write would. If the hard lock is clear, it also sets the lock bit of every byte it actually wrote, limited to lockable bytes.
- R3: In the lock window at 0x3800, the word at 0x3800+4k holds the lock bytes of registers 4k..4k+3, with register 4k+j in byte lane j. In each lock byte, bit 4+b is the write enable and bit b is the new lock value for byte b. A lock bit changes only when its enable is 1 in the same write. Reads return the lock nibble in bits 3:0 of each lane and 0 in bits 7:4.
- R4: A write that strobes any locked byte leaves those bytes unchanged and returns rsp_err=1 in its response cycle. The unlocked strobed bytes in the same word are still written.
- R5: Lock bits of bytes cleared in PROT_MASK (bit 4*i+b for byte b of register i) stay 0 under lock-window writes and alias writes. Those bytes are therefore always writable.
- R6: The configuration word sits at 0x3FFC. Bit 0 is the hard lock: writing 1 sets it, and writing 0 does not clear it. Bit 1 is the user-access enable and follows each write. Writes to this word need bus_be[0]=1.
- R7: While the hard lock is 1, lock-window writes change no lock bit and return no error. Alias writes still update the register but lock nothing.
- R8: If bus_user=1 and the user-access enable is 0, an access to any offset writes nothing and returns rdata 0 with rsp_err=1. Once the enable is 1, user accesses behave like supervisor accesses.
- R9: An unmapped offset reads as 0, returns rsp_err=1, and a write to it changes nothing. Unmapped offsets are: plain or alias offsets at or above 4*N_REGS, lock words past the last register, and configuration-window words other than 0x3FFC.
- R10: Reset clears all registers, all lock bits, the hard lock and the user-access enable. rsp_valid is 1 exactly in the cycle after each accepted bus_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte offset within the module |
| bus_be | input | 4 | Byte strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_user | input | 1 | Access is made in user mode |
| rsp_valid | output | 1 | Response strobe, one cycle after bus_req |
| rsp_rdata | output | 32 | Read data; 0 for writes and refused accesses |
| rsp_err | output | 1 | Error: locked byte, refused user access or unmapped offset |

## Verification
The bench writes partly locked words. A design that dropped the whole word, or that wrote through the locked bytes, would show the wrong merged value or a missing error. It sets lock bytes whose enable nibble selects only some bits, or none. Any write that ignores the enables would visibly change lock state. It sets locks on registers whose bytes are only partly lockable, or not lockable at all, to catch a lock mask that is applied in the wrong place. It tries to clear the hard lock and to edit locks under it, and it probes offsets just past the bank in every window, where decode that wraps or aliases would corrupt register 0.

// File: rtl/regprot_pkg.sv
package regprot_pkg;

  localparam int ADDR_W = 14;
  localparam int IDX_W  = 12;

  localparam logic [ADDR_W-1:0] ALIAS_OFF = 14'h2000;
  localparam logic [ADDR_W-1:0] LOCK_OFF  = 14'h3800;
  localparam logic [ADDR_W-1:0] CFG_OFF   = 14'h3E00;
  localparam logic [ADDR_W-1:0] CTRL_OFF  = 14'h3FFC;

  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_PLAIN,
    WIN_ALIAS,
    WIN_LOCK,
    WIN_CTRL
  } win_e;

  typedef struct packed {
    win_e             win;
    logic [IDX_W-1:0] idx;
  } dec_t;

  // Window decode: idx is the register index for data windows and the
  // lock word index for the lock window.
  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input int nregs);
    dec_t d;
    logic [ADDR_W-1:0] rel;
    d.win = WIN_NONE;
    d.idx = '0;
    rel   = '0;
    if (a < ALIAS_OFF) begin
      d.idx = {1'b0, a[12:2]};
      if (int'(d.idx) < nregs) d.win = WIN_PLAIN;
    end else if (a < LOCK_OFF) begin
      rel   = a - ALIAS_OFF;
      d.idx = {1'b0, rel[12:2]};
      if (int'(d.idx) < nregs) d.win = WIN_ALIAS;
    end else if (a < CFG_OFF) begin
      rel   = a - LOCK_OFF;
      d.idx = {2'b0, rel[11:2]};
      if (int'(d.idx) * 4 < nregs) d.win = WIN_LOCK;
    end else if (a[ADDR_W-1:2] == CTRL_OFF[ADDR_W-1:2]) begin
      d.win = WIN_CTRL;
    end
    return d;
  endfunction

  // Lock byte update: upper nibble enables, lower nibble values.
  function automatic logic [3:0] lock_apply(input logic [3:0] old, input logic [7:0] ctl);
    return (old & ~ctl[7:4]) | (ctl[3:0] & ctl[7:4]);
  endfunction

  function automatic logic [31:0] ctrl_pack(input logic hard, input logic user_en);
    return {30'b0, user_en, hard};
  endfunction

endpackage

// File: rtl/regprot_bank.sv
module regprot_bank #(
  parameter int N_REGS = 8,
  parameter int IDX_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       wr_mask,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data
);

  logic [32*N_REGS-1:0] words_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
    end else begin
      for (int i = 0; i < N_REGS; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          for (int b = 0; b < 4; b++) begin
            if (wr_mask[b]) words_q[32*i+8*b +: 8] <= wr_data[8*b +: 8];
          end
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = words_q[32*i +: 32];
    end
  end

endmodule

// File: rtl/regprot_locks.sv
module regprot_locks
  import regprot_pkg::*;
#(
  parameter int                    N_REGS    = 8,
  parameter logic [4*N_REGS-1:0]   PROT_MASK = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alias_set,
  input  logic [IDX_W-1:0]      alias_idx,
  input  logic [3:0]            alias_bits,
  input  logic                  lw_en,
  input  logic [IDX_W-1:0]      lw_word,
  input  logic [3:0]            lw_be,
  input  logic [31:0]           lw_data,
  input  logic                  ctrl_wr,
  input  logic [1:0]            ctrl_data,
  output logic [4*N_REGS-1:0]   slb_q,
  output logic                  hard_q,
  output logic                  user_en_q
);

  logic [4*N_REGS-1:0] slb_d;

  always_comb begin
    slb_d = slb_q;
    if (!hard_q) begin
      for (int i = 0; i < N_REGS; i++) begin
        if (alias_set && alias_idx == IDX_W'(i))
          slb_d[4*i +: 4] = slb_d[4*i +: 4] | alias_bits;
        if (lw_en && lw_word == IDX_W'(i / 4) && lw_be[i % 4])
          slb_d[4*i +: 4] = lock_apply(slb_d[4*i +: 4], lw_data[8*(i%4) +: 8]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slb_q     <= '0;
      hard_q    <= 1'b0;
      user_en_q <= 1'b0;
    end else begin
      slb_q <= slb_d & PROT_MASK;
      if (ctrl_wr) begin
        hard_q    <= hard_q | ctrl_data[0];
        user_en_q <= ctrl_data[1];
      end
    end
  end

endmodule

// File: rtl/reg_prot_wrap.sv
module reg_prot_wrap
  import regprot_pkg::*;
#(
  parameter int                  N_REGS    = 8,
  parameter logic [4*N_REGS-1:0] PROT_MASK = 32'hFF0F_FCFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_wr,
  input  logic [13:0] bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  input  logic        bus_user,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err
);

  dec_t                dec;
  logic                user_block;
  logic                acc_ok;
  logic                unmapped_hit;
  logic                is_data;
  logic                wr_data_hit;
  logic                wr_blocked;
  logic [3:0]          slb_word;
  logic [3:0]          bank_mask;
  logic                alias_set;
  logic                lw_en;
  logic                ctrl_wr;
  logic [4*N_REGS-1:0] slb_q;
  logic                hard_q;
  logic                user_en_q;
  logic [31:0]         bank_rd;
  logic [31:0]         lock_rd;
  logic [31:0]         rdata_d;
  logic                err_d;

  assign dec          = decode_addr(bus_addr, N_REGS);
  assign user_block   = bus_req && bus_user && !user_en_q;
  assign acc_ok       = bus_req && !user_block && dec.win != WIN_NONE;
  assign unmapped_hit = bus_req && !user_block && dec.win == WIN_NONE;
  assign is_data      = dec.win == WIN_PLAIN || dec.win == WIN_ALIAS;
  assign wr_data_hit  = acc_ok && bus_wr && is_data;

  always_comb begin
    slb_word = '0;
    for (int i = 0; i < N_REGS; i++) begin
      if (dec.idx == IDX_W'(i)) slb_word = slb_q[4*i +: 4];
    end
  end

  assign wr_blocked = wr_data_hit && |(bus_be & slb_word);
  assign bank_mask  = wr_data_hit ? (bus_be & ~slb_word) : 4'b0;
  assign alias_set  = wr_data_hit && dec.win == WIN_ALIAS;
  assign lw_en      = acc_ok && bus_wr && dec.win == WIN_LOCK;
  assign ctrl_wr    = acc_ok && bus_wr && dec.win == WIN_CTRL && bus_be[0];

  regprot_bank #(.N_REGS(N_REGS), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mask (bank_mask),
    .wr_idx  (dec.idx),
    .wr_data (bus_wdata),
    .rd_idx  (dec.idx),
    .rd_data (bank_rd)
  );

  regprot_locks #(.N_REGS(N_REGS), .PROT_MASK(PROT_MASK)) u_locks (
    .clk        (clk),
    .rst_n      (rst_n),
    .alias_set  (alias_set),
    .alias_idx  (dec.idx),
    .alias_bits (bank_mask),
    .lw_en      (lw_en),
    .lw_word    (dec.idx),
    .lw_be      (bus_be),
    .lw_data    (bus_wdata),
    .ctrl_wr    (ctrl_wr),
    .ctrl_data  (bus_wdata[1:0]),
    .slb_q      (slb_q),
    .hard_q     (hard_q),
    .user_en_q  (user_en_q)
  );

  // Lock word read: lane j shows register 4k+j, enable nibble reads 0.
  always_comb begin
    lock_rd = '0;
    for (int j = 0; j < 4; j++) begin
      for (int i = 0; i < N_REGS; i++) begin
        if (int'(dec.idx) * 4 + j == i) lock_rd[8*j +: 8] = {4'b0, slb_q[4*i +: 4]};
      end
    end
  end

  always_comb begin
    rdata_d = '0;
    if (acc_ok && !bus_wr) begin
      unique case (dec.win)
        WIN_PLAIN, WIN_ALIAS: rdata_d = bank_rd;
        WIN_LOCK:             rdata_d = lock_rd;
        WIN_CTRL:             rdata_d = ctrl_pack(hard_q, user_en_q);
        default:              rdata_d = '0;
      endcase
    end
  end

  assign err_d = user_block || unmapped_hit || wr_blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= bus_req;
      rsp_rdata <= rdata_d;
      rsp_err   <= bus_req && err_d;
    end
  end

endmodule

// File: rtl/reg_prot_sva.sv
module reg_prot_sva #(
  parameter int                  N_REGS    = 8,
  parameter logic [4*N_REGS-1:0] PROT_MASK = '1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_req,
  input logic                rsp_valid,
  input logic                rsp_err,
  input logic [31:0]         rsp_rdata,
  input logic                user_block,
  input logic                unmapped_hit,
  input logic                wr_blocked,
  input logic                hard_q,
  input logic [4*N_REGS-1:0] slb_q
);

  p_rsp_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> rsp_valid);

  p_no_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !rsp_valid);

  p_blocked_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> rsp_err);

  p_unlockable_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slb_q & ~PROT_MASK) == '0);

  p_hard_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hard_q |=> hard_q);

  p_locks_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hard_q |=> $stable(slb_q));

  p_user_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    user_block |=> (rsp_err && rsp_rdata == 32'h0));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_hit |=> (rsp_err && rsp_rdata == 32'h0));

endmodule

bind reg_prot_wrap reg_prot_sva #(.N_REGS(N_REGS), .PROT_MASK(PROT_MASK)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req      (bus_req),
  .rsp_valid    (rsp_valid),
  .rsp_err      (rsp_err),
  .rsp_rdata    (rsp_rdata),
  .user_block   (user_block),
  .unmapped_hit (unmapped_hit),
  .wr_blocked   (wr_blocked),
  .hard_q       (hard_q),
  .slb_q        (slb_q)
);

// File: tb/sim_reg_prot_wrap.sv
`timescale 1ns/1ps
module sim_reg_prot_wrap;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_wr = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_user = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  reg_prot_wrap u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_user(bus_user), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [13:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic usr,
                      output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    bus_be = be; bus_user = usr;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; bus_be = '0; bus_user = 1'b0;
    chk("R10", "rsp_valid", {31'b0, rsp_valid}, 32'h1);
    rd = rsp_rdata;
    er = rsp_err;
  endtask

  task automatic do_wr(input logic [13:0] a, input logic [31:0] d, input logic [3:0] be,
                       input logic usr, input logic exp_err, input string req);
    logic [31:0] rd;
    logic er;
    xfer(1'b1, a, d, be, usr, rd, er);
    chk(req, $sformatf("write err @%04h", a), {31'b0, er}, {31'b0, exp_err});
  endtask

  task automatic do_rd(input logic [13:0] a, input logic usr, input logic [31:0] exp_d,
                       input logic exp_err, input string req);
    logic [31:0] rd;
    logic er;
    xfer(1'b0, a, 32'h0, 4'h0, usr, rd, er);
    chk(req, $sformatf("read data @%04h", a), rd, exp_d);
    chk(req, $sformatf("read err @%04h", a), {31'b0, er}, {31'b0, exp_err});
  endtask

  task automatic t_reset();
    chk("R10", "rsp_valid idle", {31'b0, rsp_valid}, 32'h0);
    do_rd(14'h0000, 1'b0, 32'h0, 1'b0, "R10");
    do_rd(14'h3800, 1'b0, 32'h0, 1'b0, "R10");
    do_rd(14'h3FFC, 1'b0, 32'h0, 1'b0, "R10");
  endtask

  task automatic t_plain();
    do_wr(14'h0004, 32'hA5A5_1234, 4'hF, 1'b0, 1'b0, "R1");
    do_wr(14'h0006, 32'h0000_FF00, 4'h2, 1'b0, 1'b0, "R1");
    do_rd(14'h0004, 1'b0, 32'hA5A5_FF34, 1'b0, "R1");
    do_rd(14'h2004, 1'b0, 32'hA5A5_FF34, 1'b0, "R1");
  endtask

  task automatic t_alias();
    do_wr(14'h2000, 32'h1122_3344, 4'h3, 1'b0, 1'b0, "R2");
    do_rd(14'h0000, 1'b0, 32'h0000_3344, 1'b0, "R2");
    do_rd(14'h3800, 1'b0, 32'h0000_0003, 1'b0, "R2");
  endtask

  task automatic t_locked();
    do_wr(14'h0000, 32'hAAAA_AAAA, 4'hF, 1'b0, 1'b1, "R4");
    do_rd(14'h0000, 1'b0, 32'hAAAA_3344, 1'b0, "R4");
  endtask

  task automatic t_lockwin();
    // lane0 0xF0 clears reg0, lane1 0x31 sets SLB0 and clears SLB1 of reg1
    do_wr(14'h3800, 32'h0000_31F0, 4'h3, 1'b0, 1'b0, "R3");
    do_rd(14'h3800, 1'b0, 32'h0000_0100, 1'b0, "R3");
    do_wr(14'h3800, 32'h0000_0E00, 4'h2, 1'b0, 1'b0, "R3");
    do_rd(14'h3800, 1'b0, 32'h0000_0100, 1'b0, "R3");
    do_wr(14'h0004, 32'h0000_00EE, 4'h1, 1'b0, 1'b1, "R4");
    do_rd(14'h0004, 1'b0, 32'hA5A5_FF34, 1'b0, "R4");
    do_wr(14'h0000, 32'h0000_0099, 4'h1, 1'b0, 1'b0, "R3");
    do_rd(14'h0000, 1'b0, 32'hAAAA_3399, 1'b0, "R3");
  endtask

  task automatic t_unlockable();
    do_wr(14'h3800, 32'h00FF_0000, 4'h4, 1'b0, 1'b0, "R5");
    do_rd(14'h3800, 1'b0, 32'h000C_0100, 1'b0, "R5");
    do_wr(14'h0008, 32'hFFFF_FFFF, 4'hF, 1'b0, 1'b1, "R5");
    do_rd(14'h0008, 1'b0, 32'h0000_FFFF, 1'b0, "R5");
    do_wr(14'h2014, 32'h5566_7788, 4'hF, 1'b0, 1'b0, "R5");
    do_rd(14'h3804, 1'b0, 32'h0000_0000, 1'b0, "R5");
    do_wr(14'h3804, 32'h0000_FF00, 4'h2, 1'b0, 1'b0, "R5");
    do_rd(14'h3804, 1'b0, 32'h0000_0000, 1'b0, "R5");
    do_wr(14'h0014, 32'h0102_0304, 4'hF, 1'b0, 1'b0, "R5");
    do_rd(14'h0014, 1'b0, 32'h0102_0304, 1'b0, "R5");
  endtask

  task automatic t_user();
    do_rd(14'h0004, 1'b1, 32'h0, 1'b1, "R8");
    do_wr(14'h000C, 32'h0000_DEAD, 4'hF, 1'b1, 1'b1, "R8");
    do_rd(14'h000C, 1'b0, 32'h0, 1'b0, "R8");
    do_wr(14'h3FFC, 32'h0000_0002, 4'hF, 1'b1, 1'b1, "R8");
    do_rd(14'h3FFC, 1'b0, 32'h0, 1'b0, "R8");
    do_wr(14'h3FFC, 32'h0000_0002, 4'h1, 1'b0, 1'b0, "R8");
    do_wr(14'h000C, 32'hCAFE_F00D, 4'hF, 1'b1, 1'b0, "R8");
    do_rd(14'h000C, 1'b1, 32'hCAFE_F00D, 1'b0, "R8");
    do_wr(14'h3FFC, 32'h0000_0000, 4'h1, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_unmapped();
    do_rd(14'h0020, 1'b0, 32'h0, 1'b1, "R9");
    do_wr(14'h0020, 32'hFFFF_FFFF, 4'hF, 1'b0, 1'b1, "R9");
    do_rd(14'h2020, 1'b0, 32'h0, 1'b1, "R9");
    do_rd(14'h3808, 1'b0, 32'h0, 1'b1, "R9");
    do_wr(14'h3808, 32'hFFFF_FFFF, 4'hF, 1'b0, 1'b1, "R9");
    do_rd(14'h3E00, 1'b0, 32'h0, 1'b1, "R9");
    do_rd(14'h0000, 1'b0, 32'hAAAA_3399, 1'b0, "R9");
    do_rd(14'h3800, 1'b0, 32'h000C_0100, 1'b0, "R9");
  endtask

  task automatic t_hard();
    do_wr(14'h3FFC, 32'h0000_0003, 4'h1, 1'b0, 1'b0, "R6");
    do_rd(14'h3FFC, 1'b0, 32'h0000_0003, 1'b0, "R6");
    do_wr(14'h3FFC, 32'h0000_0002, 4'h1, 1'b0, 1'b0, "R6");
    do_rd(14'h3FFC, 1'b0, 32'h0000_0003, 1'b0, "R6");
    do_wr(14'h3FFC, 32'h0000_0000, 4'h1, 1'b0, 1'b0, "R6");
    do_rd(14'h3FFC, 1'b0, 32'h0000_0001, 1'b0, "R6");
    do_wr(14'h3800, 32'h0000_F000, 4'h2, 1'b0, 1'b0, "R7");
    do_rd(14'h3800, 1'b0, 32'h000C_0100, 1'b0, "R7");
    do_wr(14'h2018, 32'h1234_5678, 4'hF, 1'b0, 1'b0, "R7");
    do_rd(14'h0018, 1'b0, 32'h1234_5678, 1'b0, "R7");
    do_rd(14'h3804, 1'b0, 32'h0000_0000, 1'b0, "R7");
    do_wr(14'h0018, 32'h0000_009A, 4'h1, 1'b0, 1'b0, "R7");
    do_rd(14'h0018, 1'b0, 32'h1234_569A, 1'b0, "R7");
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_rd(14'h3FFC, 1'b0, 32'h0, 1'b0, "R10");
    do_rd(14'h3800, 1'b0, 32'h0, 1'b0, "R10");
    do_rd(14'h0004, 1'b0, 32'h0, 1'b0, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_alias();
    t_locked();
    t_lockwin();
    t_unlockable();
    t_user();
    t_unmapped();
    t_hard();
    t_reset_again();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule